// File: doc/BRIEF.md
# Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block connects a simple synchronous request port to a DRAM that uses active-low chip enable, read/write, row strobe and column strobe lines, with one shared address bus. Each request address is split into a row field (upper bits) and a column field (lower bits). The controller leaves a row open after an access. A later access to the same row only pulses the column strobe. An access to a different row first precharges, and then opens the new row.

A free-running timer raises a refresh request at an interval derived from the retention time, the clock frequency and the number of rows. The controller serves that request with a CAS-before-RAS cycle. Refresh wins over a new user request: any open row is closed first, and user traffic waits until the refresh is over. All strobe widths and gaps are counted in controller clock cycles and set by parameters.

The state machine has seven states. `ST_IDLE` waits, with the row strobe low if a row is open. `ST_PRECH` holds the row strobe high for T_RP cycles. `ST_ROW` drives the row address with the row strobe low for T_RCD cycles. `ST_COL` drives the column address with the column strobe low for T_CAS cycles. `ST_REF_CAS` lowers the column strobe alone for T_REF_LEAD cycles. `ST_REF_RAS` adds the row strobe for T_CAS cycles. `ST_REF_REC` holds both strobes high for T_RP cycles.

The transitions are:
- IDLE→PRECH: refresh is pending with a row open, or a request misses the open row.
- IDLE→REF_CAS: refresh is pending with no row open.
- IDLE→ROW: a request arrives with no row open.
- IDLE→COL: a request hits the open row.
- PRECH→REF_CAS: refresh is pending at the end of precharge.
- PRECH→ROW: no refresh is pending at the end of precharge.
- ROW→COL, COL→IDLE, REF_CAS→REF_RAS, REF_RAS→REF_REC and REF_REC→IDLE: the state's count has run out.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is asserted, the row strobe, column strobe and chip enable are high (inactive), and done is low.
- R2: With no row open, an accepted request pulls the row strobe low with the row address on the pin bus. T_RCD cycles later the column strobe falls with the column address. Done is first seen T_RCD+T_CAS+1 clock edges after the request is driven.
- R3: A request to the open row causes no row-strobe edge. Only a column strobe pulse is made, and done is first seen T_CAS+1 edges after the request.
- R4: A request to a row other than the open one raises the row strobe for T_RP cycles, then opens the new row. Done is first seen T_RP+T_RCD+T_CAS+1 edges after the request.
- R5: While the column strobe is low for a user access, the read/write line is low for a write and high for a read. The data output enable is high exactly for a write, and the data output carries the write data. The chip enable is low whenever either strobe is low.
- R6: Done is high for exactly one cycle per access. In a read's done cycle, the read data output holds the word the DRAM returned. The requester holds req, we, addr and wdata until done, and drops req in the done cycle.
- R7: Refresh lowers the column strobe while the row strobe is high, and only then lowers the row strobe. Two refreshes are never further apart than REF_INTERVAL = RETENTION_US*CLK_MHZ/(2*2^ROW_W) cycles plus the longest access and precharge.
- R8: Before a refresh starts, the row strobe has been high for at least T_RP cycles. No user column strobe occurs while a refresh is in progress, and a request that meets a refresh waits for it to finish.
- R9: After a refresh no row is open, so the next access opens its row again with a row strobe edge.
- R10: The row field is addr[ROW_W+COL_W-1:COL_W] and the column field is addr[COL_W-1:0]. Each field is driven on the low bits of the pin address bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until done |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Word address, row field above column field |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| dram_ce_n | output | 1 | Chip enable, active low |
| dram_rw_n | output | 1 | High = read, low = write |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_a | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
A directed sequence runs through each path in turn:
- a first access to a closed row;
- hits on that row;
- a miss to another row;
- read-back across rows;
- a long idle gap that forces a refresh while a row is open.

Each path has a distinct latency and a distinct pattern of strobe edges, so together they show whether the controller sorts a request into the right path. A pseudo-random run then confines its addresses to four rows, so hits, misses and collisions with refresh all occur often. A behavioural DRAM stores writes at the address latched from the strobes, so a wrong row or column split shows up as wrong read data. The per-clock monitor checks the order of the strobes around each refresh, and checks that no user column strobe occurs while a refresh is in progress.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ROW,
        ST_COL,
        ST_REF_CAS,
        ST_REF_RAS,
        ST_REF_REC
    } dram_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] tick_q;
    logic          wrap;

    assign wrap = (tick_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            pend   <= 1'b0;
        end else begin
            tick_q <= wrap ? '0 : tick_q + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_delay_cnt.sv
module dram_delay_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dram_page_pkg::*;
#(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DATA_W       = 8,
    parameter int CLK_MHZ      = 125,
    parameter int RETENTION_US = 1000,
    parameter int T_RP         = 2,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_REF_LEAD   = 1
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       req,
    input  logic                                       we,
    input  logic [ROW_W+COL_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                          wdata,
    output logic [DATA_W-1:0]                          rdata,
    output logic                                       done,
    output logic                                       dram_ce_n,
    output logic                                       dram_rw_n,
    output logic                                       dram_ras_n,
    output logic                                       dram_cas_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
    output logic [DATA_W-1:0]                          dram_dq_out,
    output logic                                       dram_dq_oe,
    input  logic [DATA_W-1:0]                          dram_dq_in
);
    localparam int PIN_W        = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int ROWS         = 1 << ROW_W;
    localparam int REF_INTERVAL = (RETENTION_US * CLK_MHZ) / (2 * ROWS);
    localparam int DLY_MAX      = max2(max2(T_RP, T_RCD), max2(T_CAS, T_REF_LEAD));
    localparam int CW           = $clog2(DLY_MAX + 1);

    dram_state_e       st_q, st_d;
    logic              row_open_q;
    logic [ROW_W-1:0]  open_row_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic              take_req;
    logic              ref_pend;
    logic              ref_ack;
    logic              dly_load;
    logic              dly_last;
    logic [CW-1:0]     dly_val;

    assign req_row  = addr[ROW_W+COL_W-1:COL_W];
    assign req_col  = addr[COL_W-1:0];
    assign take_req = req && !done_q;
    assign dly_load = (st_d != st_q);
    assign ref_ack  = (st_d == ST_REF_CAS) && (st_q != ST_REF_CAS);

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    dram_delay_cnt #(.W(CW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .load_val(dly_val),
        .last    (dly_last)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ref_pend)
                    st_d = row_open_q ? ST_PRECH : ST_REF_CAS;
                else if (take_req) begin
                    if (!row_open_q)
                        st_d = ST_ROW;
                    else if (open_row_q == req_row)
                        st_d = ST_COL;
                    else
                        st_d = ST_PRECH;
                end
            end
            ST_PRECH:   if (dly_last) st_d = ref_pend ? ST_REF_CAS : ST_ROW;
            ST_ROW:     if (dly_last) st_d = ST_COL;
            ST_COL:     if (dly_last) st_d = ST_IDLE;
            ST_REF_CAS: if (dly_last) st_d = ST_REF_RAS;
            ST_REF_RAS: if (dly_last) st_d = ST_REF_REC;
            ST_REF_REC: if (dly_last) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // dwell count for the state being entered
    always_comb begin
        unique case (st_d)
            ST_PRECH:   dly_val = CW'(T_RP - 1);
            ST_ROW:     dly_val = CW'(T_RCD - 1);
            ST_COL:     dly_val = CW'(T_CAS - 1);
            ST_REF_CAS: dly_val = CW'(T_REF_LEAD - 1);
            ST_REF_RAS: dly_val = CW'(T_CAS - 1);
            ST_REF_REC: dly_val = CW'(T_RP - 1);
            default:    dly_val = '0;
        endcase
    end

    // state register and open-row bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            row_open_q <= 1'b0;
            open_row_q <= '0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_COL) && dly_last;
            if ((st_q == ST_COL) && dly_last && !we)
                rdata_q <= dram_dq_in;
            if (st_d == ST_PRECH)
                row_open_q <= 1'b0;
            else if ((st_q == ST_ROW) && (st_d == ST_COL)) begin
                row_open_q <= 1'b1;
                open_row_q <= req_row;
            end
        end
    end

    // pin outputs
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_rw_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_dq_out = '0;
        dram_a      = '0;
        unique case (st_q)
            ST_IDLE:    dram_ras_n = !row_open_q;
            ST_ROW: begin
                dram_ras_n = 1'b0;
                dram_a     = PIN_W'(req_row);
            end
            ST_COL: begin
                dram_ras_n  = 1'b0;
                dram_cas_n  = 1'b0;
                dram_a      = PIN_W'(req_col);
                dram_rw_n   = !we;
                dram_dq_oe  = we;
                dram_dq_out = wdata;
            end
            ST_REF_CAS: dram_cas_n = 1'b0;
            ST_REF_RAS: begin
                dram_cas_n = 1'b0;
                dram_ras_n = 1'b0;
            end
            default: ;
        endcase
        dram_ce_n = (st_q == ST_IDLE) && !row_open_q;
    end

    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic dram_ce_n,
    input logic dram_rw_n,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_dq_oe
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6

    AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));  // R2

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));  // R7

    AST_REF_FROM_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_ras_n) |-> $past(dram_ras_n));  // R8

    AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_ras_n) |-> (dram_dq_oe == !dram_rw_n));  // R5

    AST_CE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n || !dram_cas_n) |-> !dram_ce_n);  // R5
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .dram_ce_n (dram_ce_n),
    .dram_rw_n (dram_rw_n),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/test_dram_page_ctrl.sv
`timescale 1ns/1ps
module test_dram_page_ctrl;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
    localparam int CLK_MHZ = 125, RET_US = 20;
    localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, T_LEAD = 1;
    localparam int COLS = 1 << COL_W, ROWS = 1 << ROW_W;
    localparam int REF_INT = (RET_US * CLK_MHZ) / (2 * ROWS);
    localparam int LAT_HIT = T_CAS + 1;
    localparam int LAT_CLOSED = T_RCD + T_CAS + 1;
    localparam int LAT_MISS = T_RP + T_RCD + T_CAS + 1;
    localparam int REF_SLACK = 2 * T_RP + T_RCD + T_CAS + 4;

    logic clk = 0, rst_n = 0;
    logic req = 0, we = 0;
    logic [ROW_W+COL_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0, rdata, dram_dq_out, dram_dq_in;
    logic done, dram_ce_n, dram_rw_n, dram_ras_n, dram_cas_n, dram_dq_oe;
    logic [COL_W-1:0] dram_a;

    always #4 clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ),
        .RETENTION_US(RET_US), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_REF_LEAD(T_LEAD)
    ) i_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done(done), .dram_ce_n(dram_ce_n), .dram_rw_n(dram_rw_n),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_a(dram_a),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    logic [DATA_W-1:0] mem [ROWS*COLS];
    logic [DATA_W-1:0] shadow [ROWS*COLS];
    int lat_row = 0;
    logic p_ras = 1, p_cas = 1;
    int ras_high_run = 0, ref_count = 0, last_ref_cyc = 0, ref_end_cyc = -100;
    bit in_ref = 0, cur_active = 0, opened_in_acc = 0;
    bit b_valid = 0;
    int b_row = 0, b_ref = 0;

    function automatic void check(bit ok, string rq, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endfunction

    assign dram_dq_in = (!dram_ras_n && !dram_cas_n && dram_rw_n)
                        ? mem[lat_row * COLS + int'(dram_a)] : '0;

    always @(posedge clk) if (rst_n) cyc++;

    // behavioural DRAM and pin monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_ras_n) ras_high_run++; else ras_high_run = 0;
            if (!dram_ras_n || !dram_cas_n)
                check(!dram_ce_n, "R5", "chip enable during strobe", dram_ce_n, 0);
            // row open for user access
            if (p_ras && !dram_ras_n && dram_cas_n) begin
                check(cur_active, "R2", "row strobe without request", 0, 1);
                check(int'(dram_a) == int'(addr[ROW_W+COL_W-1:COL_W]), "R10", "row address",
                      int'(dram_a), int'(addr[ROW_W+COL_W-1:COL_W]));
                lat_row = int'(dram_a);
                opened_in_acc = 1;
            end
            // user column access
            if (p_cas && !dram_cas_n && !dram_ras_n) begin
                check(!in_ref, "R8", "user CAS during refresh", in_ref, 0);
                check(cur_active, "R2", "column strobe without request", 0, 1);
                check(int'(dram_a) == int'(addr[COL_W-1:0]), "R10", "column address",
                      int'(dram_a), int'(addr[COL_W-1:0]));
                check(dram_rw_n == !we, "R5", "rw line", dram_rw_n, !we);
                check(dram_dq_oe == we, "R5", "data enable", dram_dq_oe, we);
                if (!dram_rw_n) begin
                    check(dram_dq_out == wdata, "R5", "write data", dram_dq_out, wdata);
                    mem[lat_row * COLS + int'(dram_a)] = dram_dq_out;
                end
            end
            // CAS-before-RAS start
            if (p_cas && !dram_cas_n && dram_ras_n) begin
                check(ras_high_run > T_RP, "R8", "row strobe high before refresh", ras_high_run, T_RP + 1);
                check(cyc - last_ref_cyc <= REF_INT + REF_SLACK, "R7", "refresh gap",
                      cyc - last_ref_cyc, REF_INT + REF_SLACK);
                last_ref_cyc = cyc;
                in_ref = 1;
                ref_count++;
            end
            if (p_ras && !dram_ras_n && !dram_cas_n)
                check(in_ref && !p_cas, "R7", "CAS before RAS order", in_ref, 1);
            if (in_ref && dram_cas_n && !p_cas) begin
                in_ref = 0;
                ref_end_cyc = cyc;
            end
        end
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
    end

    task automatic access(bit w, int ad, int d);
        int t0, rc0, lat, row;
        bit ref_near;
        @(negedge clk);
        req = 1; we = w; addr = ad[ROW_W+COL_W-1:0]; wdata = d[DATA_W-1:0];
        row = ad >> COL_W;
        t0 = cyc; rc0 = ref_count; opened_in_acc = 0; cur_active = 1;
        ref_near = in_ref || (cyc - ref_end_cyc <= T_RP + 1);
        if (w) shadow[ad] = d[DATA_W-1:0];
        do @(negedge clk); while (!done && cyc - t0 < 200);
        lat = cyc - t0;
        if (!done) check(0, "R6", "done never came", 0, 1);
        if (ref_near || ref_count != rc0) begin
            check(opened_in_acc, "R9", "row reopened after refresh", opened_in_acc, 1);
            check(lat >= LAT_CLOSED, "R8", "request waited for refresh", lat, LAT_CLOSED);
        end else if (!(b_valid && b_ref == rc0)) begin
            check(lat == LAT_CLOSED, "R2", "closed-row latency", lat, LAT_CLOSED);
        end else if (b_row == row) begin
            check(lat == LAT_HIT, "R3", "page-hit latency", lat, LAT_HIT);
            check(!opened_in_acc, "R3", "no row strobe on hit", opened_in_acc, 0);
        end else begin
            check(lat == LAT_MISS, "R4", "row-miss latency", lat, LAT_MISS);
        end
        if (!w) check(rdata == shadow[ad], "R6", "read data", rdata, shadow[ad]);
        b_valid = 1; b_row = row; b_ref = ref_count;
        req = 0; cur_active = 0;
        @(negedge clk);
        check(!done, "R6", "done one cycle", done, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        check(0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < ROWS * COLS; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
        repeat (4) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_ce_n, "R1", "strobes idle in reset",
              {dram_ras_n, dram_cas_n, dram_ce_n}, 7);
        check(!done, "R1", "done low in reset", done, 0);
        rst_n = 1;
        // directed: closed, hit, hit, miss, hit, miss, hit
        access(1, 8'h30, 8'hA1);
        access(1, 8'h31, 8'hB2);
        access(1, 8'h32, 8'hC3);
        access(1, 8'h57, 8'hD4);
        access(0, 8'h57, 0);
        access(0, 8'h31, 0);
        access(0, 8'h30, 0);
        // long idle: refresh with an open row, then a fresh open
        repeat (REF_INT + 20) @(negedge clk);
        check(ref_count >= 1, "R7", "refresh occurred", ref_count, 1);
        access(0, 8'h32, 0);
        // pseudo-random traffic over four rows
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            int a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = ((int'(lfsr[1:0]) * 3) << COL_W) | int'(lfsr[7:4]);
            access(lfsr[8], a, int'(lfsr[15:8]));
            repeat (int'(lfsr[10:9])) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule